// File: doc/BRIEF.md
# Serial Shift Engine with Bus Condition Detectors

This block is a bare serial engine for software-driven transfers. It holds one 8-bit shift register, which is the data register itself, and a 4-bit counter that advances on every active clock edge, so sixteen edges move one byte. The shift clock comes either from a software strobe or from the external clock line. When it comes from the line, the block samples on one edge and updates the output latch on the other. Framing, addressing and acknowledge policy are left to software. Software polls the counter-overflow flag to learn that a transfer has ended.

A wire-mode field changes only how the two line outputs behave. In three-wire mode the outputs drive both levels, which suits SPI modes 0 and 1. No slave select is provided. In two-wire mode the outputs can only pull low or let go. In that mode two detectors watch the synchronised data and clock lines and flag start and stop conditions. Both line inputs pass through a synchroniser. Line events are therefore seen a few system clocks after they happen on the pins.

There is no stream interface. The data register, the counter and the flags are reached through plain load and clear strobes. Each load takes effect at the next clock, so no back-pressure is needed.

Top module: `ser_shift_engine`

## Requirements
- R1: After reset the shift register, the counter and all three flags are 0, the output latch is 0, the clock-port value is 1, and both output enables are 0 (wire mode 00).
- R2: A pulse on `dr_wr` loads `dr_wdata` into the shift register, which `dr_rdata` shows on the next cycle with no buffering. The output latch takes bit 7 of the loaded value.
- R3: With `clk_src`=10, a rising edge of the clock line shifts the data line in at bit 0, moving the other bits toward the MSB. The falling edge then loads the output latch from bit 7. In three-wire mode (`wire_mode`=01) `dat_o` shows the latch.
- R4: With `clk_src`=11 the roles of the edges swap. A falling edge shifts the data line in, and a rising edge loads the latch from bit 7.
- R5: With either external clock source the counter advances by one on every rising and every falling edge of the clock line, so 16 edges shift 8 bits.
- R6: The overflow flag sets when the counter wraps from 15 to 0 and stays set until a cycle with `flag_clr` bit 0 high. Clear bits 1 and 2 leave it unchanged.
- R7: With `clk_src`=00, each `sw_strobe` pulse shifts in one bit and advances the counter by one. On the same cycle the latch takes the bit that becomes the new MSB.
- R8: With `clk_src`=01, neither strobes nor clock-line edges change the shift register or the counter.
- R9: In two-wire mode (`wire_mode`=1x), the data line falling while the clock line stays high sets the start flag, and `flag_clr` bit 1 clears it. In other modes the flag is never set.
- R10: In two-wire mode, the data line rising while the clock line stays high sets the stop flag, and `flag_clr` bit 2 clears it. In other modes the flag is never set.
- R11: In two-wire mode `dat_o` and `sck_o` are 0. `dat_oe` is high only when `data_drive` is set and the latch is 0, and `sck_oe` is high only when `clk_drive` is set and the clock-port value is 0.
- R12: In wire mode 00 both output enables are 0.
- R13: A pulse on `cnt_wr` loads `cnt_wdata` into the counter, and `cnt_o` shows it on the next cycle.
- R14: Each `sw_toggle` pulse inverts the clock-port value. In three-wire mode `sck_o` shows that value and `sck_oe` equals `clk_drive`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wire_mode | input | 2 | 00 off, 01 three-wire, 10/11 two-wire |
| clk_src | input | 2 | 00 software strobe, 01 halted, 10 line rising samples, 11 line falling samples |
| data_drive | input | 1 | Allows the data output to drive |
| clk_drive | input | 1 | Allows the clock output to drive |
| sw_strobe | input | 1 | Software shift/count strobe, one cycle per bit |
| sw_toggle | input | 1 | Inverts the clock-port value |
| dr_wr | input | 1 | Load strobe for the shift register |
| dr_wdata | input | 8 | Value to load into the shift register |
| cnt_wr | input | 1 | Load strobe for the edge counter |
| cnt_wdata | input | 4 | Value to load into the counter |
| flag_clr | input | 3 | Write-one clear: bit0 overflow, bit1 start, bit2 stop |
| dat_i | input | 1 | Data line input |
| sck_i | input | 1 | Clock line input |
| dr_rdata | output | 8 | Live shift register contents |
| cnt_o | output | 4 | Edge counter value |
| ovf_flag | output | 1 | Counter overflow flag |
| start_flag | output | 1 | Start condition flag |
| stop_flag | output | 1 | Stop condition flag |
| dat_o | output | 1 | Data line output value |
| dat_oe | output | 1 | Data line output enable |
| sck_o | output | 1 | Clock line output value |
| sck_oe | output | 1 | Clock line output enable |

## Verification
A counter that misses or doubles an edge shows at `cnt_o` within a few cycles of that edge. After a full byte it also sets the overflow flag at the wrong edge, or not at all. A shift done on the wrong edge, or a latch loaded on the same edge as the sample, changes `dat_o` half a bit period early. It also leaves `dr_rdata` off by one position once the next edge arrives. A detector that ignores the mode or the clock level sets a flag at once on a data transition that should be inert. A flag with a wrong hold or clear path shows up on the first clear stimulus.

// File: rtl/ssi_pkg.sv
package ssi_pkg;
  typedef enum logic [1:0] {
    WM_OFF   = 2'b00,
    WM_THREE = 2'b01,
    WM_TWO   = 2'b10,
    WM_TWO_B = 2'b11
  } wire_mode_e;

  typedef enum logic [1:0] {
    CS_SOFT     = 2'b00,
    CS_HALT     = 2'b01,
    CS_EXT_RISE = 2'b10,
    CS_EXT_FALL = 2'b11
  } clk_src_e;

  typedef struct packed {
    logic sample;
    logic launch;
    logic count;
  } clk_evt_t;
endpackage

// File: rtl/ssi_sync.sv
module ssi_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [STAGES:0][W-1:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= '0;
    else        st <= {st[STAGES-1:0], d};
  end

  assign q      = st[STAGES-1];
  assign q_prev = st[STAGES];
endmodule

// File: rtl/ssi_clk_sel.sv
module ssi_clk_sel
  import ssi_pkg::*;
(
  input  logic [1:0] clk_src,
  input  logic       sw_strobe,
  input  logic       line_rise,
  input  logic       line_fall,
  output clk_evt_t   evt
);
  always_comb begin
    evt = '0;
    unique case (clk_src_e'(clk_src))
      CS_SOFT: begin
        evt.sample = sw_strobe;
        evt.launch = sw_strobe;
        evt.count  = sw_strobe;
      end
      CS_HALT: evt = '0;
      CS_EXT_RISE: begin
        evt.sample = line_rise;
        evt.launch = line_fall;
        evt.count  = line_rise | line_fall;
      end
      CS_EXT_FALL: begin
        evt.sample = line_fall;
        evt.launch = line_rise;
        evt.count  = line_rise | line_fall;
      end
      default: evt = '0;
    endcase
  end
endmodule

// File: rtl/ssi_shifter.sv
module ssi_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          sample,
  input  logic          launch,
  input  logic          din,
  output logic [DW-1:0] sr,
  output logic          latch
);
  localparam int MSB = DW - 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr    <= '0;
      latch <= 1'b0;
    end else if (wr) begin
      sr    <= wdata;
      latch <= wdata[MSB];
    end else begin
      if (sample) sr <= {sr[MSB-1:0], din};
      if (launch) latch <= sample ? sr[MSB-1] : sr[MSB];
    end
  end
endmodule

// File: rtl/ssi_edge_cnt.sv
module ssi_edge_cnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [CW-1:0] wdata,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  assign wrap = inc & ~wr & (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (wr)  cnt <= wdata;
    else if (inc) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ssi_bus_cond.sv
module ssi_bus_cond (
  input  logic en,
  input  logic dat_now,
  input  logic dat_old,
  input  logic sck_now,
  input  logic sck_old,
  output logic start_evt,
  output logic stop_evt
);
  logic sck_held_high;

  assign sck_held_high = sck_now & sck_old;
  assign start_evt = en & sck_held_high &  dat_old & ~dat_now;
  assign stop_evt  = en & sck_held_high & ~dat_old &  dat_now;
endmodule

// File: rtl/ser_shift_engine.sv
module ser_shift_engine
  import ssi_pkg::*;
#(
  parameter int DW          = 8,
  parameter int CW          = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    wire_mode,
  input  logic [1:0]    clk_src,
  input  logic          data_drive,
  input  logic          clk_drive,
  input  logic          sw_strobe,
  input  logic          sw_toggle,
  input  logic          dr_wr,
  input  logic [DW-1:0] dr_wdata,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_wdata,
  input  logic [2:0]    flag_clr,
  input  logic          dat_i,
  input  logic          sck_i,
  output logic [DW-1:0] dr_rdata,
  output logic [CW-1:0] cnt_o,
  output logic          ovf_flag,
  output logic          start_flag,
  output logic          stop_flag,
  output logic          dat_o,
  output logic          dat_oe,
  output logic          sck_o,
  output logic          sck_oe
);
  localparam int NLINES = 2;
  localparam int LN_DAT = 0;
  localparam int LN_SCK = 1;
  localparam int CLR_OVF = 0;
  localparam int CLR_STA = 1;
  localparam int CLR_STO = 2;

  logic [NLINES-1:0]    line_now, line_old;
  logic [SYNC_STAGES:0] arm_q;
  logic                 armed;
  logic                 sck_rise, sck_fall;
  clk_evt_t             evt;
  logic                 latch_q;
  logic                 cnt_wrap;
  logic                 start_evt, stop_evt;
  logic                 two_wire;
  logic                 clk_port_q;

  ssi_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d      ({sck_i, dat_i}),
    .q      (line_now),
    .q_prev (line_old)
  );

  // Edge and condition detection waits until the synchroniser holds real samples.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= '0;
    else        arm_q <= {arm_q[SYNC_STAGES-1:0], 1'b1};
  end
  assign armed = arm_q[SYNC_STAGES];

  assign sck_rise = armed &  line_now[LN_SCK] & ~line_old[LN_SCK];
  assign sck_fall = armed & ~line_now[LN_SCK] &  line_old[LN_SCK];

  ssi_clk_sel u_csel (
    .clk_src   (clk_src),
    .sw_strobe (sw_strobe),
    .line_rise (sck_rise),
    .line_fall (sck_fall),
    .evt       (evt)
  );

  ssi_shifter #(.DW(DW)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (dr_wr),
    .wdata  (dr_wdata),
    .sample (evt.sample),
    .launch (evt.launch),
    .din    (line_now[LN_DAT]),
    .sr     (dr_rdata),
    .latch  (latch_q)
  );

  ssi_edge_cnt #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (cnt_wr),
    .wdata (cnt_wdata),
    .inc   (evt.count),
    .cnt   (cnt_o),
    .wrap  (cnt_wrap)
  );

  assign two_wire = wire_mode[1];

  ssi_bus_cond u_cond (
    .en        (two_wire & armed),
    .dat_now   (line_now[LN_DAT]),
    .dat_old   (line_old[LN_DAT]),
    .sck_now   (line_now[LN_SCK]),
    .sck_old   (line_old[LN_SCK]),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  // Flags: a set in the same cycle as a clear wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag   <= 1'b0;
      start_flag <= 1'b0;
      stop_flag  <= 1'b0;
    end else begin
      ovf_flag   <= cnt_wrap  | (ovf_flag   & ~flag_clr[CLR_OVF]);
      start_flag <= start_evt | (start_flag & ~flag_clr[CLR_STA]);
      stop_flag  <= stop_evt  | (stop_flag  & ~flag_clr[CLR_STO]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         clk_port_q <= 1'b1;
    else if (sw_toggle) clk_port_q <= ~clk_port_q;
  end

  always_comb begin
    dat_o  = 1'b0;
    dat_oe = 1'b0;
    sck_o  = 1'b0;
    sck_oe = 1'b0;
    unique case (wire_mode_e'(wire_mode))
      WM_OFF: ;
      WM_THREE: begin
        dat_o  = latch_q;
        dat_oe = data_drive;
        sck_o  = clk_port_q;
        sck_oe = clk_drive;
      end
      WM_TWO, WM_TWO_B: begin
        dat_oe = data_drive & ~latch_q;
        sck_oe = clk_drive & ~clk_port_q;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ssi_checker.sv
module ssi_checker #(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    wire_mode,
  input logic [1:0]    clk_src,
  input logic          dr_wr,
  input logic [DW-1:0] dr_wdata,
  input logic          cnt_wr,
  input logic [2:0]    flag_clr,
  input logic [DW-1:0] dr_rdata,
  input logic [CW-1:0] cnt_o,
  input logic          ovf_flag,
  input logic          start_flag,
  input logic          stop_flag,
  input logic          dat_o,
  input logic          dat_oe,
  input logic          sck_o,
  input logic          sck_oe
);
  AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    dr_wr |=> (dr_rdata == $past(dr_wdata))); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (cnt_o == $past(cnt_o) || cnt_o == CW'($past(cnt_o) + 1'b1))); // R5
  AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> ($past(cnt_o) == {CW{1'b1}} && cnt_o == '0)); // R6
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr[0]) |=> ovf_flag); // R6
  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_src == 2'b01 && !cnt_wr && !dr_wr) |=> ($stable(cnt_o) && $stable(dr_rdata))); // R8
  AST_NO_START_3W: assert property (@(posedge clk) disable iff (!rst_n)
    !wire_mode[1] |=> !$rose(start_flag)); // R9
  AST_NO_STOP_3W: assert property (@(posedge clk) disable iff (!rst_n)
    !wire_mode[1] |=> !$rose(stop_flag)); // R10
  AST_TWO_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    wire_mode[1] |-> (!(dat_oe && dat_o) && !(sck_oe && sck_o))); // R11
  AST_OFF_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (wire_mode == 2'b00) |-> (!dat_oe && !sck_oe)); // R12
endmodule

bind ser_shift_engine ssi_checker #(.DW(DW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wire_mode  (wire_mode),
  .clk_src    (clk_src),
  .dr_wr      (dr_wr),
  .dr_wdata   (dr_wdata),
  .cnt_wr     (cnt_wr),
  .flag_clr   (flag_clr),
  .dr_rdata   (dr_rdata),
  .cnt_o      (cnt_o),
  .ovf_flag   (ovf_flag),
  .start_flag (start_flag),
  .stop_flag  (stop_flag),
  .dat_o      (dat_o),
  .dat_oe     (dat_oe),
  .sck_o      (sck_o),
  .sck_oe     (sck_oe)
);

// File: tb/tb_ser_shift_engine.sv
module tb_ser_shift_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] wire_mode = 2'b00;
  logic [1:0] clk_src = 2'b10;
  logic       data_drive = 1'b0, clk_drive = 1'b0;
  logic       sw_strobe = 1'b0, sw_toggle = 1'b0;
  logic       dr_wr = 1'b0;
  logic [7:0] dr_wdata = '0;
  logic       cnt_wr = 1'b0;
  logic [3:0] cnt_wdata = '0;
  logic [2:0] flag_clr = '0;
  logic       dat_i = 1'b0, sck_i = 1'b0;
  logic [7:0] dr_rdata;
  logic [3:0] cnt_o;
  logic       ovf_flag, start_flag, stop_flag, dat_o, dat_oe, sck_o, sck_oe;

  always #10 clk = ~clk;

  ser_shift_engine dut (
    .clk(clk), .rst_n(rst_n), .wire_mode(wire_mode), .clk_src(clk_src),
    .data_drive(data_drive), .clk_drive(clk_drive), .sw_strobe(sw_strobe),
    .sw_toggle(sw_toggle), .dr_wr(dr_wr), .dr_wdata(dr_wdata), .cnt_wr(cnt_wr),
    .cnt_wdata(cnt_wdata), .flag_clr(flag_clr), .dat_i(dat_i), .sck_i(sck_i),
    .dr_rdata(dr_rdata), .cnt_o(cnt_o), .ovf_flag(ovf_flag), .start_flag(start_flag),
    .stop_flag(stop_flag), .dat_o(dat_o), .dat_oe(dat_oe), .sck_o(sck_o), .sck_oe(sck_oe)
  );

  localparam int S_DR = 0, S_CNT = 1, S_OVF = 2, S_STA = 3, S_STO = 4,
                 S_DO = 5, S_DOE = 6, S_SCK = 7, S_SCKOE = 8;

  typedef struct {
    string      req;
    string      what;
    int         sel;
    logic [7:0] exp;
  } item_t;

  item_t sb[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  function automatic logic [7:0] observe(int sel);
    case (sel)
      S_DR:    return dr_rdata;
      S_CNT:   return {4'b0, cnt_o};
      S_OVF:   return {7'b0, ovf_flag};
      S_STA:   return {7'b0, start_flag};
      S_STO:   return {7'b0, stop_flag};
      S_DO:    return {7'b0, dat_o};
      S_DOE:   return {7'b0, dat_oe};
      S_SCK:   return {7'b0, sck_o};
      default: return {7'b0, sck_oe};
    endcase
  endfunction

  // Monitor: pops expected items and compares them away from the clock edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      while (sb.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it  = sb.pop_front();
        act = observe(it.sel);
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s %s: actual=0x%02h expected=0x%02h", it.req, it.what, act, it.exp);
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(string req, string what, int sel, logic [7:0] exp);
    item_t it;
    it.req = req; it.what = what; it.sel = sel; it.exp = exp;
    sb.push_back(it);
    do @(posedge clk); while (sb.size() != 0);
    @(negedge clk);
  endtask

  task automatic load_dr(logic [7:0] v);
    dr_wr = 1'b1; dr_wdata = v; tick(1);
    dr_wr = 1'b0; tick(1);
  endtask

  task automatic clear_flags(logic [2:0] m);
    flag_clr = m; tick(1);
    flag_clr = '0; tick(1);
  endtask

  task automatic strobe();
    sw_strobe = 1'b1; tick(1);
    sw_strobe = 1'b0; tick(1);
  endtask

  task automatic toggle_clk();
    sw_toggle = 1'b1; tick(1);
    sw_toggle = 1'b0; tick(1);
  endtask

  task automatic set_sck(logic v);
    sck_i = v; tick(5);
  endtask

  task automatic set_dat(logic v);
    dat_i = v; tick(5);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx_byte;
    rx_byte = 8'h3C;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1: reset state
    expect_out("R1", "shift register", S_DR, 8'h00);
    expect_out("R1", "counter", S_CNT, 8'h00);
    expect_out("R1", "overflow flag", S_OVF, 8'h00);
    expect_out("R1", "start flag", S_STA, 8'h00);
    expect_out("R1", "stop flag", S_STO, 8'h00);
    expect_out("R1", "data enable", S_DOE, 8'h00);
    expect_out("R1", "clock enable", S_SCKOE, 8'h00);

    // R2: load and immediate readback, latch from MSB
    wire_mode = 2'b01; data_drive = 1'b1; clk_src = 2'b10;
    tick(4);
    load_dr(8'hA5);
    expect_out("R2", "loaded value", S_DR, 8'hA5);
    expect_out("R2", "latch from bit7", S_DO, 8'h01);
    expect_out("R2", "three-wire data enable", S_DOE, 8'h01);

    // R3/R5/R6: one byte on external clock, sampling on rising edge
    for (int i = 7; i >= 0; i--) begin
      set_dat(rx_byte[i]);
      set_sck(1'b1);
      if (i == 7) begin
        expect_out("R3", "shift on rising edge", S_DR, 8'h4A);
        expect_out("R3", "latch holds until falling", S_DO, 8'h01);
        expect_out("R5", "count after one edge", S_CNT, 8'h01);
      end
      set_sck(1'b0);
      if (i == 7) expect_out("R3", "latch on falling edge", S_DO, 8'h00);
    end
    expect_out("R3", "received byte", S_DR, 8'h3C);
    expect_out("R5", "counter wrapped after 16 edges", S_CNT, 8'h00);
    expect_out("R6", "overflow set on wrap", S_OVF, 8'h01);
    clear_flags(3'b110);
    expect_out("R6", "other clear bits ignored", S_OVF, 8'h01);
    clear_flags(3'b001);
    expect_out("R6", "overflow cleared", S_OVF, 8'h00);

    // R4: sampling on falling edge
    clk_src = 2'b11;
    tick(1);
    load_dr(8'h40);
    set_dat(1'b1);
    set_sck(1'b1);
    expect_out("R4", "rising edge does not shift", S_DR, 8'h40);
    expect_out("R5", "rising edge counted", S_CNT, 8'h01);
    set_sck(1'b0);
    expect_out("R4", "falling edge shifts", S_DR, 8'h81);
    expect_out("R4", "latch unchanged on falling", S_DO, 8'h00);
    set_sck(1'b1);
    expect_out("R4", "latch on rising edge", S_DO, 8'h01);
    expect_out("R5", "three edges counted", S_CNT, 8'h03);

    // R13 and R7: counter load, software strobe
    cnt_wr = 1'b1; cnt_wdata = 4'd14; tick(1);
    cnt_wr = 1'b0; tick(1);
    expect_out("R13", "counter load", S_CNT, 8'h0E);
    clk_src = 2'b00;
    tick(1);
    load_dr(8'h40);
    dat_i = 1'b1; tick(3);
    strobe();
    expect_out("R7", "strobe shift", S_DR, 8'h81);
    expect_out("R7", "latch takes new MSB", S_DO, 8'h01);
    expect_out("R7", "strobe count", S_CNT, 8'h0F);
    dat_i = 1'b0; tick(3);
    strobe();
    expect_out("R7", "second strobe shift", S_DR, 8'h02);
    expect_out("R7", "latch takes new MSB again", S_DO, 8'h00);
    expect_out("R6", "overflow from strobe wrap", S_OVF, 8'h01);
    clear_flags(3'b001);

    // R8: halted clock source ignores everything
    clk_src = 2'b01;
    tick(1);
    set_sck(1'b0);
    set_sck(1'b1);
    strobe();
    expect_out("R8", "register frozen", S_DR, 8'h02);
    expect_out("R8", "counter frozen", S_CNT, 8'h00);

    // R14: clock port toggle in three-wire mode
    clk_drive = 1'b1; tick(1);
    expect_out("R14", "clock port reset value", S_SCK, 8'h01);
    expect_out("R14", "clock enable follows drive", S_SCKOE, 8'h01);
    toggle_clk();
    expect_out("R14", "clock port toggled", S_SCK, 8'h00);

    // R11: two-wire outputs only pull low
    wire_mode = 2'b10; tick(1);
    expect_out("R11", "data pulls low for latch 0", S_DOE, 8'h01);
    expect_out("R11", "data value low", S_DO, 8'h00);
    expect_out("R11", "clock pulls low for port 0", S_SCKOE, 8'h01);
    load_dr(8'h80);
    expect_out("R11", "data released for latch 1", S_DOE, 8'h00);
    toggle_clk();
    expect_out("R11", "clock released for port 1", S_SCKOE, 8'h00);

    // R9/R10: start and stop in two-wire mode
    set_sck(1'b0);
    set_dat(1'b1);
    set_sck(1'b1);
    expect_out("R9", "no start on clock rise", S_STA, 8'h00);
    expect_out("R10", "no stop on clock rise", S_STO, 8'h00);
    set_dat(1'b0);
    expect_out("R9", "start detected", S_STA, 8'h01);
    expect_out("R10", "start is not stop", S_STO, 8'h00);
    clear_flags(3'b010);
    expect_out("R9", "start cleared", S_STA, 8'h00);
    set_dat(1'b1);
    expect_out("R10", "stop detected", S_STO, 8'h01);
    clear_flags(3'b100);
    expect_out("R10", "stop cleared", S_STO, 8'h00);

    // R9/R10 negative: three-wire mode never flags
    wire_mode = 2'b01; tick(1);
    set_dat(1'b0);
    expect_out("R9", "no start in three-wire", S_STA, 8'h00);
    set_dat(1'b1);
    expect_out("R10", "no stop in three-wire", S_STO, 8'h00);

    // R12: off mode releases outputs
    wire_mode = 2'b00; tick(1);
    expect_out("R12", "data released", S_DOE, 8'h00);
    expect_out("R12", "clock released", S_SCKOE, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule